// File: doc/BRIEF.md
# MAC Pause Interval Controller

This block sits beside a transmit MAC and decides when that MAC must stop sending because a link partner asked it to pause. An upstream receive parser presents each candidate pause frame as a one-cycle strobe. With the strobe come the frame's 48-bit destination address, its 16-bit pause quanta, and a flag that says the address already hit a station filter. The block checks the request against the enabled address modes. On acceptance it loads a down-counter measured in slot times and raises a hold output toward the transmitter until the count runs out.

Software sees everything through one 32-bit control/status word on a plain write-strobe bus, with read data always present. Reception is enabled either by a software bit or by a registered negotiation status. Clearing the software bit cuts an interval short. Software may also start an interval by hand, but only when the timer is idle. The count field reads back the live counter value.

Top module: `mac_pause_ctrl`

## Requirements
- R1: After a synchronous reset the status word reads 0x00000000 and `tx_hold` is low.
- R2: Bit 31 (software enable), bit 30 (multicast mode) and bit 29 (station-match mode) are written and read back. Bits 28:24 and 20:17 always read 0. Bit 16 (load strobe) always reads 0.
- R3: Frames are accepted only while bit 31 or bit 21 reads 1. Otherwise a frame leaves the counter, bit 23, bit 22 and `tx_hold` unchanged.
- R4: Bit 21 equals `neg_status AND adv_capable`, registered one cycle.
- R5: With bit 30 set, a frame qualifies only if `frm_da` equals exactly 48'h0180C2000001.
- R6: With bit 29 set, a frame qualifies when `frm_da_hit` is 1, whatever its address.
- R7: An accepted frame with nonzero quanta takes effect at the next edge. The count field (bits 15:0) takes the quanta, bit 23 (active) and bit 22 (received) become 1, and `tx_hold` becomes 1.
- R8: While active, each cycle with `slot_tick` high lowers the count by one. At the edge where the count reaches 0, bits 23 and 22 and `tx_hold` clear.
- R9: An accepted frame with quanta 0 ends any interval: the count goes to 0 and bits 23 and 22 clear.
- R10: An accepted frame during an interval reloads the count with its own quanta.
- R11: A write with bit 16 set and a nonzero count in bits 15:0 has an effect only when bits 23 and 22 both read 0. In that case it loads the count, sets bit 23 and leaves bit 22 at 0. In every other case it does not touch the timer.
- R12: A write with bit 31 = 0 while bit 31 reads 1 ends any interval at once, even if bit 21 is 1.
- R13: When events coincide, the order is: abort write, then accepted frame, then manual load, then slot tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Write strobe for the status word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Current status word |
| neg_status | input | 1 | Pause agreed by link negotiation |
| adv_capable | input | 1 | Local pause capability is advertised |
| frm_valid | input | 1 | One-cycle strobe for a parsed pause frame |
| frm_da | input | 48 | Destination address of the frame |
| frm_quanta | input | 16 | Requested pause length in slot times |
| frm_da_hit | input | 1 | Address matched a station filter upstream |
| slot_tick | input | 1 | One pulse per slot time (512 bit times) |
| tx_hold | output | 1 | Hold-off to the transmit MAC |

## Verification
The hardest situations to reach are collisions between events on a single edge. Examples are an abort write landing with an accepted frame, a frame arriving on the same edge as the final tick, and a manual load attempted while the received flag is still set. Directed steps line up each collision on one exact cycle. A long random phase then mixes sparse writes, frames with the exact group address or near-miss addresses, and dense ticks. A behavioural model checks every field of the status word on every cycle.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int CSR_W   = 32;
  localparam int CNT_W   = 16;
  localparam int ADDR_W  = 48;

  localparam int B_SWEN  = 31;
  localparam int B_MCAST = 30;
  localparam int B_STMAT = 29;
  localparam int B_ACT   = 23;
  localparam int B_RCV   = 22;
  localparam int B_NEG   = 21;
  localparam int B_LOAD  = 16;

  localparam logic [ADDR_W-1:0] GROUP_DA = 48'h0180C2000001;

  typedef struct packed {
    logic sw_en;
    logic mcast;
    logic stmat;
  } mode_t;

  typedef enum logic [2:0] {
    TM_HOLD,
    TM_CLEAR,
    TM_LOAD_RX,
    TM_LOAD_SW,
    TM_TICK,
    TM_EXPIRE
  } tm_op_e;
endpackage

// File: rtl/pause_csr.sv
module pause_csr
  import pause_pkg::*;
#(
  parameter int DW = CSR_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          neg_status,
  input  logic          adv_capable,
  input  logic [CW-1:0] cnt,
  input  logic          active,
  input  logic          rcvd,
  output mode_t         mode,
  output logic          neg_q,
  output logic          abort_req,
  output logic          man_req,
  output logic [CW-1:0] man_val,
  output logic [DW-1:0] rdata
);
  localparam int RES_LO_W = B_LOAD - CW;

  mode_t mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      neg_q  <= 1'b0;
    end else begin
      neg_q <= neg_status & adv_capable;
      if (wr) begin
        mode_q.sw_en <= wdata[B_SWEN];
        mode_q.mcast <= wdata[B_MCAST];
        mode_q.stmat <= wdata[B_STMAT];
      end
    end
  end

  assign mode      = mode_q;
  assign abort_req = wr & ~wdata[B_SWEN] & mode_q.sw_en;
  assign man_val   = wdata[CW-1:0];
  assign man_req   = wr & wdata[B_LOAD] & (wdata[CW-1:0] != '0);

  always_comb begin
    rdata          = '0;
    rdata[B_SWEN]  = mode_q.sw_en;
    rdata[B_MCAST] = mode_q.mcast;
    rdata[B_STMAT] = mode_q.stmat;
    rdata[B_ACT]   = active;
    rdata[B_RCV]   = rcvd;
    rdata[B_NEG]   = neg_q;
    rdata[CW-1:0]  = cnt;
  end

  if (RES_LO_W < 0) begin : g_bad_width
    initial $error("count width exceeds field");
  end
endmodule

// File: rtl/pause_qual.sv
module pause_qual
  import pause_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] MATCH_DA = GROUP_DA
) (
  input  logic          frm_valid,
  input  logic [AW-1:0] frm_da,
  input  logic          frm_da_hit,
  input  mode_t         mode,
  input  logic          neg_q,
  output logic          accept
);
  localparam int NBYTES = AW / 8;

  logic [NBYTES-1:0] byte_eq;
  logic              group_hit;
  logic              rx_on;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign byte_eq[b] = (frm_da[b*8 +: 8] == MATCH_DA[b*8 +: 8]);
  end

  assign group_hit = &byte_eq;
  assign rx_on     = mode.sw_en | neg_q;
  assign accept    = frm_valid & rx_on &
                     ((mode.mcast & group_hit) | (mode.stmat & frm_da_hit));
endmodule

// File: rtl/pause_timer.sv
module pause_timer
  import pause_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort_req,
  input  logic          accept,
  input  logic [CW-1:0] quanta,
  input  logic          man_req,
  input  logic [CW-1:0] man_val,
  input  logic          slot_tick,
  output logic [CW-1:0] cnt,
  output logic          active,
  output logic          rcvd
);
  localparam logic [CW-1:0] ONE = CW'(1);

  tm_op_e op;

  always_comb begin
    op = TM_HOLD;
    if (abort_req) begin
      op = TM_CLEAR;
    end else if (accept) begin
      op = (quanta == '0) ? TM_CLEAR : TM_LOAD_RX;
    end else if (man_req && !active && !rcvd) begin
      op = TM_LOAD_SW;
    end else if (active && slot_tick) begin
      op = (cnt == ONE) ? TM_EXPIRE : TM_TICK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
      rcvd   <= 1'b0;
    end else begin
      unique case (op)
        TM_CLEAR, TM_EXPIRE: begin
          cnt    <= '0;
          active <= 1'b0;
          rcvd   <= 1'b0;
        end
        TM_LOAD_RX: begin
          cnt    <= quanta;
          active <= 1'b1;
          rcvd   <= 1'b1;
        end
        TM_LOAD_SW: begin
          cnt    <= man_val;
          active <= 1'b1;
        end
        TM_TICK: cnt <= cnt - ONE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mac_pause_ctrl.sv
module mac_pause_ctrl
  import pause_pkg::*;
#(
  parameter int DW = CSR_W,
  parameter int CW = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csr_wr,
  input  logic [DW-1:0] csr_wdata,
  output logic [DW-1:0] csr_rdata,
  input  logic          neg_status,
  input  logic          adv_capable,
  input  logic          frm_valid,
  input  logic [AW-1:0] frm_da,
  input  logic [CW-1:0] frm_quanta,
  input  logic          frm_da_hit,
  input  logic          slot_tick,
  output logic          tx_hold
);
  mode_t         mode;
  logic          neg_q, abort_req, man_req, accept;
  logic [CW-1:0] man_val, cnt;
  logic          active, rcvd;

  pause_csr #(.DW(DW), .CW(CW)) u_csr (
    .clk        (clk),
    .rst        (rst),
    .wr         (csr_wr),
    .wdata      (csr_wdata),
    .neg_status (neg_status),
    .adv_capable(adv_capable),
    .cnt        (cnt),
    .active     (active),
    .rcvd       (rcvd),
    .mode       (mode),
    .neg_q      (neg_q),
    .abort_req  (abort_req),
    .man_req    (man_req),
    .man_val    (man_val),
    .rdata      (csr_rdata)
  );

  pause_qual #(.AW(AW)) u_qual (
    .frm_valid (frm_valid),
    .frm_da    (frm_da),
    .frm_da_hit(frm_da_hit),
    .mode      (mode),
    .neg_q     (neg_q),
    .accept    (accept)
  );

  pause_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .abort_req(abort_req),
    .accept   (accept),
    .quanta   (frm_quanta),
    .man_req  (man_req),
    .man_val  (man_val),
    .slot_tick(slot_tick),
    .cnt      (cnt),
    .active   (active),
    .rcvd     (rcvd)
  );

  assign tx_hold = active;
endmodule

// File: rtl/mac_pause_ctrl_chk.sv
module mac_pause_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        csr_wr,
  input logic [31:0] csr_wdata,
  input logic [31:0] csr_rdata,
  input logic        adv_capable,
  input logic        frm_valid,
  input logic        slot_tick,
  input logic        tx_hold
);
  AST_ACTIVE_IFF_COUNT: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[23] == (csr_rdata[15:0] != 16'd0)); // R8

  AST_RCVD_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[22] |-> tx_hold); // R7

  AST_TICK_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (tx_hold && slot_tick && !csr_wr && !frm_valid)
      |=> csr_rdata[15:0] == $past(csr_rdata[15:0]) - 16'd1); // R8

  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && !csr_wdata[31] && csr_rdata[31]) |=> !tx_hold); // R12

  AST_NEG_NEEDS_ADV: assert property (@(posedge clk) disable iff (rst)
    $rose(csr_rdata[21]) |-> $past(adv_capable)); // R4

  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !csr_rdata[31] && !csr_rdata[21] && !csr_wr && !tx_hold)
      |=> !tx_hold); // R3

  AST_MANUAL_NO_RCVD: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && csr_wdata[16] && !frm_valid && !tx_hold && !csr_rdata[22])
      |=> !csr_rdata[22]); // R11
endmodule

bind mac_pause_ctrl mac_pause_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .csr_wr     (csr_wr),
  .csr_wdata  (csr_wdata),
  .csr_rdata  (csr_rdata),
  .adv_capable(adv_capable),
  .frm_valid  (frm_valid),
  .slot_tick  (slot_tick),
  .tx_hold    (tx_hold)
);

// File: tb/tb_mac_pause_ctrl.sv
module tb_mac_pause_ctrl;
  localparam logic [47:0] GDA = 48'h0180C2000001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        neg_status = 1'b0, adv_capable = 1'b0;
  logic        frm_valid = 1'b0, frm_da_hit = 1'b0, slot_tick = 1'b0;
  logic [47:0] frm_da = '0;
  logic [15:0] frm_quanta = '0;
  logic        tx_hold;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  mac_pause_ctrl dut (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .neg_status(neg_status), .adv_capable(adv_capable),
    .frm_valid(frm_valid), .frm_da(frm_da), .frm_quanta(frm_quanta),
    .frm_da_hit(frm_da_hit), .slot_tick(slot_tick), .tx_hold(tx_hold)
  );

  // Behavioural reference
  bit m_sw, m_mc, m_st, m_neg, m_act, m_rcv;
  int m_cnt;
  bit e_abort, e_acc, e_man, e_rx;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_sw = 0; m_mc = 0; m_st = 0; m_neg = 0; m_act = 0; m_rcv = 0; m_cnt = 0;
    end else begin
      e_abort = csr_wr && !csr_wdata[31] && m_sw;
      e_rx    = m_sw || m_neg;
      e_acc   = frm_valid && e_rx &&
                ((m_mc && frm_da == GDA) || (m_st && frm_da_hit));
      e_man   = csr_wr && csr_wdata[16] && csr_wdata[15:0] != 0 && !m_act && !m_rcv;
      if (e_abort) begin
        m_cnt = 0; m_act = 0; m_rcv = 0;
      end else if (e_acc) begin
        if (frm_quanta == 0) begin m_cnt = 0; m_act = 0; m_rcv = 0; end
        else begin m_cnt = frm_quanta; m_act = 1; m_rcv = 1; end
      end else if (e_man) begin
        m_cnt = csr_wdata[15:0]; m_act = 1;
      end else if (m_act && slot_tick) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin m_act = 0; m_rcv = 0; end
      end
      m_neg = neg_status && adv_capable;
      if (csr_wr) begin
        m_sw = csr_wdata[31]; m_mc = csr_wdata[30]; m_st = csr_wdata[29];
      end
    end
    #1;
    if (!rst) begin
      chk(csr_rdata[15:0] == 16'(m_cnt), "R8 count", {16'd0, csr_rdata[15:0]}, m_cnt);
      chk(csr_rdata[23] == m_act, "R7 active", {31'd0, csr_rdata[23]}, {31'd0, m_act});
      chk(csr_rdata[22] == m_rcv, "R7 received", {31'd0, csr_rdata[22]}, {31'd0, m_rcv});
      chk(tx_hold == m_act, "R7 tx_hold", {31'd0, tx_hold}, {31'd0, m_act});
      chk(csr_rdata[21] == m_neg, "R4 negotiated", {31'd0, csr_rdata[21]}, {31'd0, m_neg});
      chk(csr_rdata[31:29] == {m_sw, m_mc, m_st}, "R2 mode bits",
          {29'd0, csr_rdata[31:29]}, {29'd0, m_sw, m_mc, m_st});
      chk(csr_rdata[28:24] == 0 && csr_rdata[20:16] == 0, "R2 reserved",
          csr_rdata, csr_rdata & 32'hE0E0FFFF);
    end
  end

  // One-cycle stimulus helpers, driven on the falling edge
  task automatic cyc(input bit wr, input logic [31:0] wd, input bit fv,
                     input logic [47:0] da, input logic [15:0] q, input bit hit,
                     input bit tick);
    @(negedge clk);
    csr_wr = wr; csr_wdata = wd; frm_valid = fv; frm_da = da;
    frm_quanta = q; frm_da_hit = hit; slot_tick = tick;
    @(negedge clk);
    csr_wr = 0; frm_valid = 0; frm_da_hit = 0; slot_tick = 0;
  endtask

  task automatic wr_csr(input logic [31:0] wd);
    cyc(1, wd, 0, '0, '0, 0, 0);
  endtask

  task automatic frame(input logic [47:0] da, input logic [15:0] q, input bit hit);
    cyc(0, '0, 1, da, q, hit, 0);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(csr_rdata == 0, "R1 reset word", csr_rdata, 0);
    chk(tx_hold == 0, "R1 reset hold", {31'd0, tx_hold}, 0);
    rst = 0;

    wr_csr(32'hFF1E0000);
    chk(csr_rdata == 32'hE0000000, "R2 readback", csr_rdata, 32'hE0000000);
    wr_csr(32'h0);

    wr_csr(32'h40000000);
    frame(GDA, 16'd9, 0);
    chk(tx_hold == 0, "R3 disabled frame ignored", {31'd0, tx_hold}, 0);

    @(negedge clk); neg_status = 1; adv_capable = 0;
    @(negedge clk);
    chk(csr_rdata[21] == 0, "R4 no advertise", {31'd0, csr_rdata[21]}, 0);
    adv_capable = 1;
    @(negedge clk);
    chk(csr_rdata[21] == 1, "R4 negotiated", {31'd0, csr_rdata[21]}, 1);

    frame(GDA, 16'd5, 0);
    chk(csr_rdata[23:22] == 2'b11 && csr_rdata[15:0] == 5, "R5 R7 group accept",
        csr_rdata, 32'h40E00005);
    chk(tx_hold == 1, "R3 enable via negotiation", {31'd0, tx_hold}, 1);
    for (int i = 4; i >= 0; i--) begin
      cyc(0, '0, 0, '0, '0, 0, 1);
      chk(csr_rdata[15:0] == 16'(i), "R8 tick count", {16'd0, csr_rdata[15:0]}, i);
    end
    chk(csr_rdata[23:22] == 0 && !tx_hold, "R8 expiry", csr_rdata, 32'h40200000);

    frame(GDA ^ 48'h000000000100, 16'd6, 0);
    chk(!tx_hold, "R5 near-miss address", {31'd0, tx_hold}, 0);
    frame(48'h123456789ABC, 16'd6, 1);
    chk(!tx_hold, "R6 hit with mode off", {31'd0, tx_hold}, 0);

    wr_csr(32'hA0000000);
    frame(48'h123456789ABC, 16'd100, 1);
    chk(csr_rdata[15:0] == 100, "R6 station hit", {16'd0, csr_rdata[15:0]}, 100);
    frame(48'h123456789ABC, 16'd7, 1);
    chk(csr_rdata[15:0] == 7, "R10 reload", {16'd0, csr_rdata[15:0]}, 7);
    frame(48'h123456789ABC, 16'd0, 1);
    chk(csr_rdata[23:22] == 0 && csr_rdata[15:0] == 0, "R9 zero quanta",
        csr_rdata, 32'hA0200000);

    wr_csr(32'hA0010000);
    chk(!tx_hold, "R11 zero manual count", {31'd0, tx_hold}, 0);
    wr_csr(32'hA0010014);
    chk(csr_rdata[23:22] == 2'b10 && csr_rdata[15:0] == 20, "R11 manual load",
        csr_rdata, 32'hA0A00014);
    wr_csr(32'hA0010003);
    chk(csr_rdata[15:0] == 20, "R11 load while active", {16'd0, csr_rdata[15:0]}, 20);
    wr_csr(32'h20000000);
    chk(!tx_hold && csr_rdata[15:0] == 0, "R12 abort", csr_rdata, 32'h20200000);

    wr_csr(32'hA0000000);
    frame(48'h1, 16'd1, 1);
    cyc(0, '0, 1, 48'h1, 16'd4, 1, 1);
    chk(csr_rdata[15:0] == 4 && tx_hold, "R13 frame over tick", {16'd0, csr_rdata[15:0]}, 4);
    cyc(1, 32'h20000000, 1, 48'h1, 16'd8, 1, 0);
    chk(!tx_hold, "R13 abort over frame", {31'd0, tx_hold}, 0);
    wr_csr(32'hA0000000);
    cyc(1, 32'hA0010009, 1, 48'h1, 16'd3, 1, 0);
    chk(csr_rdata[15:0] == 3 && csr_rdata[22], "R13 frame over manual",
        {16'd0, csr_rdata[15:0]}, 3);

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      csr_wr     = ($urandom_range(0, 19) == 0);
      csr_wdata  = $urandom & 32'hE001001F;
      frm_valid  = ($urandom_range(0, 9) == 0);
      frm_da     = ($urandom_range(0, 1) == 0) ? GDA : (GDA ^ (48'h1 << $urandom_range(0, 47)));
      frm_quanta = 16'($urandom_range(0, 12));
      frm_da_hit = $urandom_range(0, 1) == 1;
      slot_tick  = $urandom_range(0, 2) == 0;
      if ($urandom_range(0, 199) == 0) neg_status = ~neg_status;
    end
    @(negedge clk);
    csr_wr = 0; frm_valid = 0; slot_tick = 0;
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule